// File: doc/BRIEF.md
# Serial Command Register Decoder

This block sits behind the byte-level slave interface of a serial control bus. It turns a stream of written and read bytes into accesses to a small configuration register file. The bus front end gives three strobes. A transaction-start strobe carries a direction flag. A write-byte strobe carries a data byte. A read-byte request is answered with `rd_data`. The first byte written in a transaction is a command code. Each later byte is a parameter, numbered by its position. A read streams the bytes of the register that the last command selected.

The register file holds a configuration byte, an active-time byte, a debounce count, a keypad geometry byte, a clock setting, three 16-bit GPIO words, an interrupt status byte and a sticky error byte. Every parameter is validated on arrival. A command that has taken its last parameter leaves the selected command at the spent code 0xFF, so any surplus byte is reported as a bad parameter. The block also fills a word memory that holds LED dimming scripts. Start and halt requests for the three script engines are passed on as single-cycle pulses to an external sequencer, which reads the memory through its own port.

Top module: `cmd_decoder`

## Requirements
- R1: `xfer_start` clears the byte index. In a write transaction the byte at index 0 becomes the command and the byte at index k≥1 is parameter k-1. Write strobes are ignored in a transaction started with `xfer_is_write`=0.
- R2: After reset the block holds these values: config 0x80, status 0x10 (bit 4 = not initialised), active time 125, debounce 3, keypad size 0x33, clock 0x08, error 0x00. `irq_n` is low.
- R3: Command 0x83 with parameter 0xAA restores every R2 value except the error byte. Any other parameter leaves those values unchanged, sets error bit 0 (bad parameter) and sets status bit 3 (error).
- R4: Commands 0x84 (pull), 0x85 (direction) and 0x86 (state) each take two bytes. The first byte sets the low byte and clears the high byte. The second byte ORs into the high byte and ends the command. A read of 0x87 (direction) or 0x88 (state) returns the low byte and then the high byte.
- R5: Command 0x90 stores the keypad size. It flags a bad parameter unless bits 3:0 are in 3..12 and bits 7:4 are in 3..8. Command 0x8F stores the debounce value and flags a value of 0 as a bad parameter.
- R6: Command 0x93 stores the clock byte and flags a bad parameter when bits 1:0 are 01 or 10. A read of 0x94 returns the stored byte with bits 1:0 replaced by 10.
- R7: A read of 0x80 returns 0x00 and then 0x04, and 0x00 after that. A read of 0x92 returns the low nibble of the config byte.
- R8: Command 0x81 stores the config byte, clears the status and ends the command. `irq_n` is high exactly when the status is zero.
- R9: When the selected command is 0xFF, a written parameter byte sets error bit 0 and status bit 3.
- R10: A write parameter or a read under an unrecognised command (for example 0x99 or 0x8D) sets error bit 1 and status bit 3, and the read returns 0x00. A read of 0x8C returns the error byte.
- R11: Command 0x95 takes three bytes: address, high byte, low byte. The address is rejected as a bad parameter, and the command ends, when bits 1:0 are 0 or bits 7:2 exceed 59. An accepted write stores the word at that address, readable on `scr_rdata` at `scr_raddr`.
- R12: Command 0x96 checks its byte as in R11. On success it pulses `eng_start` for one cycle with `eng_sel` set to bits 1:0 and `eng_addr` set to bits 7:2. Command 0x97 pulses `eng_stop` with `eng_sel` set to bits 1:0 and rejects a value of 0 with no pulse.
- R13: A read of 0x82 returns the status byte. The status is cleared after that read unless bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Transaction start strobe |
| xfer_is_write | input | 1 | Direction of the starting transaction (1 = write) |
| wr_stb | input | 1 | Written byte valid |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Read byte request; advances the index |
| rd_data | output | 8 | Byte returned for the current index |
| irq_n | output | 1 | Low while any status bit is set |
| cfg_byte | output | 8 | Configuration byte |
| act_time | output | 8 | Active time |
| debounce | output | 8 | Debounce count |
| key_size | output | 8 | Keypad geometry |
| clk_cfg | output | 8 | Clock setting |
| gpio_pull | output | 16 | Pull select word |
| gpio_dir | output | 16 | Direction word |
| gpio_state | output | 16 | State word |
| eng_start | output | 1 | One-cycle engine start request |
| eng_stop | output | 1 | One-cycle engine halt request |
| eng_sel | output | 2 | Engine index of the request |
| eng_addr | output | 6 | Start address of the request |
| scr_raddr | input | 8 | Script memory read address |
| scr_rdata | output | 16 | Script memory read word |

## Verification
A wrong byte index shows up at once. Parameters land in the wrong half of a GPIO word, or a 16-bit read returns its bytes in the wrong order, on the next strobe. If the command does not fall back to the spent code, an extra byte goes unreported: error bit 0 and `irq_n` then stay untouched in the cycle after the strobe. A validation slip shows either as a missing pulse or as a spurious error bit, one cycle after the parameter's strobe. Register contents can be seen directly on the configuration outputs in that same cycle.

// File: rtl/cmd_decoder_pkg.sv
// Shared command codes, bit positions and reset values of the decoder.
package cmd_decoder_pkg;
    localparam logic [7:0] C_ID_RD     = 8'h80;
    localparam logic [7:0] C_CFG_WR    = 8'h81;
    localparam logic [7:0] C_STAT_RD   = 8'h82;
    localparam logic [7:0] C_RESET     = 8'h83;
    localparam logic [7:0] C_PULL_WR   = 8'h84;
    localparam logic [7:0] C_DIR_WR    = 8'h85;
    localparam logic [7:0] C_STATE_WR  = 8'h86;
    localparam logic [7:0] C_DIR_RD    = 8'h87;
    localparam logic [7:0] C_STATE_RD  = 8'h88;
    localparam logic [7:0] C_ACT_WR    = 8'h8B;
    localparam logic [7:0] C_ERR_RD    = 8'h8C;
    localparam logic [7:0] C_ROT_RD    = 8'h8E;
    localparam logic [7:0] C_DEB_WR    = 8'h8F;
    localparam logic [7:0] C_SIZE_WR   = 8'h90;
    localparam logic [7:0] C_SIZE_RD   = 8'h91;
    localparam logic [7:0] C_CFG_RD    = 8'h92;
    localparam logic [7:0] C_CLK_WR    = 8'h93;
    localparam logic [7:0] C_CLK_RD    = 8'h94;
    localparam logic [7:0] C_SCR_WR    = 8'h95;
    localparam logic [7:0] C_ENG_GO    = 8'h96;
    localparam logic [7:0] C_ENG_HALT  = 8'h97;
    localparam logic [7:0] C_SPENT     = 8'hFF;

    localparam logic [7:0] RESET_KEY   = 8'hAA;
    localparam logic [15:0] ID_WORD    = 16'h0400;

    localparam int ERRB_BADPAR  = 0;
    localparam int ERRB_UNKNOWN = 1;
    localparam int STB_ERROR    = 3;
    localparam int STB_NOINIT   = 4;

    localparam logic [7:0] RV_CFG    = 8'h80;
    localparam logic [7:0] RV_STATUS = 8'h10;
    localparam logic [7:0] RV_ACT    = 8'd125;
    localparam logic [7:0] RV_DEB    = 8'd3;
    localparam logic [7:0] RV_SIZE   = 8'h33;
    localparam logic [7:0] RV_CLK    = 8'h08;
endpackage

// File: rtl/byte_index.sv
// Byte position counter within one bus transaction.
// Assumes start and advance strobes are never asserted in the same cycle;
// the count saturates at its maximum so long transactions cannot wrap.
module byte_index #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    // Clear on start, count each byte, hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || start) idx <= '0;
        else if (adv && idx != IDX_MAX) idx <= idx + 1'b1;
    end
endmodule

// File: rtl/param_check.sv
// Validation of the first parameter byte of each command.
// Purely combinational; the caller decides when the result applies.
module param_check
    import cmd_decoder_pkg::*;
#(
    parameter int KEY_MIN  = 3,
    parameter int ROW_MAX  = 12,
    parameter int COL_MAX  = 8,
    parameter int SCR_LAST = 59
) (
    input  logic [7:0] cmd,
    input  logic [7:0] data,
    output logic       bad
);
    logic addr_bad;
    logic size_bad;

    // Shared address rule for script write and engine start.
    always_comb addr_bad = (data[1:0] == 2'b00) || (int'(data[7:2]) > SCR_LAST);

    // Keypad geometry limits on both nibbles.
    always_comb size_bad = (int'(data[3:0]) < KEY_MIN) || (int'(data[3:0]) > ROW_MAX)
                        || (int'(data[7:4]) < KEY_MIN) || (int'(data[7:4]) > COL_MAX);

    // Select the rule of the current command.
    always_comb begin
        unique case (cmd)
            C_RESET:    bad = (data != RESET_KEY);
            C_DEB_WR:   bad = (data == 8'h00);
            C_SIZE_WR:  bad = size_bad;
            C_CLK_WR:   bad = data[1] ^ data[0];
            C_SCR_WR,
            C_ENG_GO:   bad = addr_bad;
            C_ENG_HALT: bad = (data[1:0] == 2'b00);
            default:    bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/script_mem.sv
// Word memory for dimming scripts with a clear-then-byte-fill write port
// and an asynchronous read port. Contents are not reset.
module script_mem #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    logic [15:0] mem [DEPTH];

    // Clear a word, or fill one of its bytes.
    always_ff @(posedge clk) begin
        if (clr)        mem[waddr]       <= '0;
        else if (wr_hi) mem[waddr][15:8] <= mem[waddr][15:8] | wdata;
        else if (wr_lo) mem[waddr][7:0]  <= mem[waddr][7:0] | wdata;
    end

    // Read port for the external sequencer.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/cmd_decoder.sv
// Command decoder for a byte-oriented serial slave. It latches a command
// from the first written byte, applies later bytes as indexed parameters,
// and serves reads of the selected register. Assumes xfer_start, wr_stb and
// rd_req are one-cycle strobes that never coincide.
module cmd_decoder
    import cmd_decoder_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int SCR_DEPTH = 256,
    parameter int SCR_AW    = $clog2(SCR_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_is_write,
    input  logic              wr_stb,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    output logic [7:0]        rd_data,
    output logic              irq_n,
    output logic [7:0]        cfg_byte,
    output logic [7:0]        act_time,
    output logic [7:0]        debounce,
    output logic [7:0]        key_size,
    output logic [7:0]        clk_cfg,
    output logic [15:0]       gpio_pull,
    output logic [15:0]       gpio_dir,
    output logic [15:0]       gpio_state,
    output logic              eng_start,
    output logic              eng_stop,
    output logic [1:0]        eng_sel,
    output logic [5:0]        eng_addr,
    input  logic [SCR_AW-1:0] scr_raddr,
    output logic [15:0]       scr_rdata
);
    localparam logic [IDX_W-1:0] I0 = IDX_W'(0);
    localparam logic [IDX_W-1:0] I1 = IDX_W'(1);
    localparam logic [IDX_W-1:0] I2 = IDX_W'(2);
    localparam logic [IDX_W-1:0] I3 = IDX_W'(3);

    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        cmd_q;
    logic              wr_mode_q;
    logic [7:0]        status_q;
    logic [7:0]        err_q;
    logic [SCR_AW-1:0] faddr_q;
    logic              wr_ok;
    logic              bad;
    logic              first;
    logic              mem_clr, mem_hi, mem_lo;

    byte_index #(.IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .start(xfer_start),
        .adv(wr_ok || rd_req), .idx(idx_q)
    );

    param_check u_chk (.cmd(cmd_q), .data(wr_data), .bad(bad));

    // Accepted write strobe and first-parameter flag.
    always_comb begin
        wr_ok = wr_stb && wr_mode_q;
        first = (idx_q == I1);
    end

    // Script memory byte-write controls.
    always_comb begin
        mem_clr = wr_ok && cmd_q == C_SCR_WR && first && !bad;
        mem_hi  = wr_ok && cmd_q == C_SCR_WR && idx_q == I2;
        mem_lo  = wr_ok && cmd_q == C_SCR_WR && idx_q == I3;
    end

    script_mem #(.DEPTH(SCR_DEPTH)) u_mem (
        .clk(clk), .clr(mem_clr), .wr_hi(mem_hi), .wr_lo(mem_lo),
        .waddr(mem_clr ? wr_data[SCR_AW-1:0] : faddr_q), .wdata(wr_data),
        .raddr(scr_raddr), .rdata(scr_rdata)
    );

    // Command latch, register file updates and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= C_SPENT;  wr_mode_q <= 1'b0;
            cfg_byte <= RV_CFG;  status_q <= RV_STATUS;  act_time <= RV_ACT;
            debounce <= RV_DEB;  key_size <= RV_SIZE;    clk_cfg <= RV_CLK;
            err_q <= '0;  gpio_pull <= '0;  gpio_dir <= '0;  gpio_state <= '0;
            faddr_q <= '0;  eng_start <= 1'b0;  eng_stop <= 1'b0;
            eng_sel <= '0;  eng_addr <= '0;
        end else begin
            eng_start <= 1'b0;
            eng_stop  <= 1'b0;
            if (xfer_start) wr_mode_q <= xfer_is_write;
            if (wr_ok && idx_q == I0) begin
                cmd_q <= wr_data;
            end else if (wr_ok) begin
                unique case (cmd_q)
                    C_CFG_WR: begin
                        cfg_byte <= wr_data;  status_q <= '0;  cmd_q <= C_SPENT;
                    end
                    C_RESET: begin
                        cmd_q <= C_SPENT;
                        if (bad) begin
                            err_q[ERRB_BADPAR] <= 1'b1;  status_q[STB_ERROR] <= 1'b1;
                        end else begin
                            cfg_byte <= RV_CFG;  status_q <= RV_STATUS;  act_time <= RV_ACT;
                            debounce <= RV_DEB;  key_size <= RV_SIZE;    clk_cfg <= RV_CLK;
                        end
                    end
                    C_PULL_WR:
                        if (first) gpio_pull <= {8'h00, wr_data};
                        else begin gpio_pull[15:8] <= gpio_pull[15:8] | wr_data; cmd_q <= C_SPENT; end
                    C_DIR_WR:
                        if (first) gpio_dir <= {8'h00, wr_data};
                        else begin gpio_dir[15:8] <= gpio_dir[15:8] | wr_data; cmd_q <= C_SPENT; end
                    C_STATE_WR:
                        if (first) gpio_state <= {8'h00, wr_data};
                        else begin gpio_state[15:8] <= gpio_state[15:8] | wr_data; cmd_q <= C_SPENT; end
                    C_ACT_WR: begin act_time <= wr_data; cmd_q <= C_SPENT; end
                    C_DEB_WR, C_SIZE_WR, C_CLK_WR: begin
                        if (cmd_q == C_DEB_WR)  debounce <= wr_data;
                        if (cmd_q == C_SIZE_WR) key_size <= wr_data;
                        if (cmd_q == C_CLK_WR)  clk_cfg  <= wr_data;
                        cmd_q <= C_SPENT;
                        if (bad) begin
                            err_q[ERRB_BADPAR] <= 1'b1;  status_q[STB_ERROR] <= 1'b1;
                        end
                    end
                    C_SCR_WR:
                        if (first) begin
                            if (bad) begin
                                err_q[ERRB_BADPAR] <= 1'b1;  status_q[STB_ERROR] <= 1'b1;
                                cmd_q <= C_SPENT;
                            end else faddr_q <= wr_data[SCR_AW-1:0];
                        end else if (idx_q == I3) cmd_q <= C_SPENT;
                    C_ENG_GO, C_ENG_HALT: begin
                        cmd_q <= C_SPENT;
                        if (bad) begin
                            err_q[ERRB_BADPAR] <= 1'b1;  status_q[STB_ERROR] <= 1'b1;
                        end else begin
                            eng_start <= (cmd_q == C_ENG_GO);
                            eng_stop  <= (cmd_q == C_ENG_HALT);
                            eng_sel   <= wr_data[1:0];
                            eng_addr  <= wr_data[7:2];
                        end
                    end
                    C_SPENT: begin
                        err_q[ERRB_BADPAR] <= 1'b1;  status_q[STB_ERROR] <= 1'b1;
                    end
                    default: begin
                        err_q[ERRB_UNKNOWN] <= 1'b1;  status_q[STB_ERROR] <= 1'b1;
                    end
                endcase
            end
            if (rd_req) begin
                unique case (cmd_q)
                    C_STAT_RD: if (!status_q[STB_NOINIT]) status_q <= '0;
                    C_ID_RD, C_DIR_RD, C_STATE_RD, C_ERR_RD, C_ROT_RD,
                    C_SIZE_RD, C_CFG_RD, C_CLK_RD: ;
                    default: begin
                        err_q[ERRB_UNKNOWN] <= 1'b1;  status_q[STB_ERROR] <= 1'b1;
                    end
                endcase
            end
        end
    end

    // Read data for the selected command and current byte position.
    always_comb begin
        unique case (cmd_q)
            C_ID_RD:    rd_data = (idx_q == I0) ? ID_WORD[7:0]
                                : (idx_q == I1) ? ID_WORD[15:8] : 8'h00;
            C_STAT_RD:  rd_data = (idx_q == I0) ? status_q : 8'h00;
            C_DIR_RD:   rd_data = (idx_q == I0) ? gpio_dir[7:0]
                                : (idx_q == I1) ? gpio_dir[15:8] : 8'h00;
            C_STATE_RD: rd_data = (idx_q == I0) ? gpio_state[7:0]
                                : (idx_q == I1) ? gpio_state[15:8] : 8'h00;
            C_ERR_RD:   rd_data = err_q;
            C_SIZE_RD:  rd_data = key_size;
            C_CFG_RD:   rd_data = {4'h0, cfg_byte[3:0]};
            C_CLK_RD:   rd_data = {clk_cfg[7:2], 2'b10};
            default:    rd_data = 8'h00;
        endcase
    end

    // Interrupt line follows any pending status bit.
    always_comb irq_n = (status_q == 8'h00);
endmodule

// File: rtl/cmd_decoder_checker.sv
// Temporal checks on the decoder, bound to every cmd_decoder instance.
module cmd_decoder_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_start,
    input logic             wr_stb,
    input logic             wr_mode,
    input logic [IDX_W-1:0] idx,
    input logic [7:0]       cmd,
    input logic [7:0]       status,
    input logic [7:0]       err,
    input logic             eng_start,
    input logic             eng_stop,
    input logic [1:0]       eng_sel
);
    // Requirement R1: a new transaction restarts at byte 0.
    p_index_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> idx == '0);

    // Requirement R9: a parameter under the spent code reports bad parameter.
    p_spent_param_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_mode && idx != '0 && cmd == 8'hFF) |=> (err[0] && status[3]));

    // Requirement R8: a config write leaves the status clear.
    p_cfg_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_mode && idx == IDX_W'(1) && cmd == 8'h81) |=> status == 8'h00);

    // Requirement R12: start and stop never coincide and name a real engine.
    p_engine_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start || eng_stop) |-> (!(eng_start && eng_stop) && eng_sel != 2'b00));

    // Requirement R12: an engine request follows an accepted write byte.
    p_engine_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start || eng_stop) |-> $past(wr_stb && wr_mode));
endmodule

bind cmd_decoder cmd_decoder_checker #(.IDX_W(IDX_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .wr_stb(wr_stb),
    .wr_mode(wr_mode_q), .idx(idx_q), .cmd(cmd_q), .status(status_q),
    .err(err_q), .eng_start(eng_start), .eng_stop(eng_stop), .eng_sel(eng_sel)
);

// File: tb/sim_cmd_decoder.sv
// Directed bench for cmd_decoder: one task per scenario.
module sim_cmd_decoder;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start = 1'b0, xfer_is_write = 1'b0, wr_stb = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic irq_n;
    logic [7:0] cfg_byte, act_time, debounce, key_size, clk_cfg;
    logic [15:0] gpio_pull, gpio_dir, gpio_state, scr_rdata;
    logic eng_start, eng_stop;
    logic [1:0] eng_sel;
    logic [5:0] eng_addr;
    logic [7:0] scr_raddr = '0;

    int checks = 0, errors = 0;
    bit done = 0;
    logic cap_go, cap_halt;
    logic [1:0] cap_sel;
    logic [5:0] cap_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_is_write(xfer_is_write),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .irq_n(irq_n), .cfg_byte(cfg_byte), .act_time(act_time), .debounce(debounce),
        .key_size(key_size), .clk_cfg(clk_cfg), .gpio_pull(gpio_pull),
        .gpio_dir(gpio_dir), .gpio_state(gpio_state), .eng_start(eng_start),
        .eng_stop(eng_stop), .eng_sel(eng_sel), .eng_addr(eng_addr),
        .scr_raddr(scr_raddr), .scr_rdata(scr_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start(input bit wr);
        @(negedge clk); xfer_start = 1'b1; xfer_is_write = wr;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v);
        @(negedge clk); wr_stb = 1'b1; wr_data = v;
        @(negedge clk); wr_stb = 1'b0;
        cap_go = eng_start; cap_halt = eng_stop; cap_sel = eng_sel; cap_addr = eng_addr;
    endtask

    task automatic rbyte(output logic [7:0] v);
        @(negedge clk); rd_req = 1'b1; #1 v = rd_data;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic wr1(input logic [7:0] c, input logic [7:0] p);
        start(1); wbyte(c); wbyte(p);
    endtask

    task automatic rd_first(input logic [7:0] c, output logic [7:0] v);
        start(1); wbyte(c); start(0); rbyte(v);
    endtask

    task automatic expect_status(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        rd_first(8'h82, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R2 cfg", cfg_byte, 8'h80);   chk("R2 act", act_time, 125);
        chk("R2 deb", debounce, 3);       chk("R2 size", key_size, 8'h33);
        chk("R2 clk", clk_cfg, 8'h08);    chk("R2 irq_n", irq_n, 0);
        rd_first(8'h8C, v); chk("R2 err", v, 8'h00);
        expect_status("R13 noinit status kept 1", 8'h10);
        expect_status("R13 noinit status kept 2", 8'h10);
    endtask

    task automatic t_id_cfg;
        logic [7:0] v;
        start(1); wbyte(8'h80); start(0);
        rbyte(v); chk("R7 id b0", v, 8'h00);
        rbyte(v); chk("R7 id b1", v, 8'h04);
        rbyte(v); chk("R7 id b2", v, 8'h00);
        wr1(8'h81, 8'h5A);
        chk("R8 cfg stored", cfg_byte, 8'h5A);
        chk("R8 irq_n high", irq_n, 1);
        rd_first(8'h92, v); chk("R7 cfg low nibble", v, 8'h0A);
        expect_status("R8 status cleared", 8'h00);
    endtask

    task automatic t_gpio;
        logic [7:0] v;
        start(1); wbyte(8'h85); wbyte(8'h34); wbyte(8'h12);
        chk("R4 dir word", gpio_dir, 16'h1234);
        start(1); wbyte(8'h86); wbyte(8'hC3); wbyte(8'h5A);
        chk("R4 state word", gpio_state, 16'h5AC3);
        start(1); wbyte(8'h84); wbyte(8'hFF); wbyte(8'h01);
        chk("R4 pull word", gpio_pull, 16'h01FF);
        start(1); wbyte(8'h87); start(0);
        rbyte(v); chk("R4 dir rd lo", v, 8'h34);
        rbyte(v); chk("R4 dir rd hi", v, 8'h12);
        start(1); wbyte(8'h88); start(0);
        rbyte(v); chk("R4 state rd lo", v, 8'hC3);
        rbyte(v); chk("R4 state rd hi", v, 8'h5A);
        chk("R1 no spurious error", irq_n, 1);
    endtask

    task automatic t_spent;
        logic [7:0] v;
        start(1); wbyte(8'h85); wbyte(8'h01); wbyte(8'h02); wbyte(8'h77);
        chk("R9 dir unchanged", gpio_dir, 16'h0201);
        chk("R9 irq_n low", irq_n, 0);
        rd_first(8'h8C, v); chk("R9 err bit0", v, 8'h01);
        expect_status("R9 status err bit", 8'h08);
        expect_status("R13 status cleared by read", 8'h00);
        chk("R13 irq_n high", irq_n, 1);
    endtask

    task automatic t_keysize;
        wr1(8'h90, 8'h8C);
        chk("R5 size stored", key_size, 8'h8C);
        expect_status("R5 size 8x12 ok", 8'h00);
        wr1(8'h90, 8'h92); expect_status("R5 rows 2 bad", 8'h08);
        wr1(8'h90, 8'h93); expect_status("R5 cols 9 bad", 8'h08);
        wr1(8'h90, 8'h33); expect_status("R5 size 3x3 ok", 8'h00);
        wr1(8'h8F, 8'h00); expect_status("R5 debounce 0 bad", 8'h08);
        wr1(8'h8F, 8'h05); expect_status("R5 debounce 5 ok", 8'h00);
        chk("R5 debounce stored", debounce, 8'h05);
    endtask

    task automatic t_clock;
        logic [7:0] v;
        wr1(8'h93, 8'h57);
        chk("R6 clock stored", clk_cfg, 8'h57);
        expect_status("R6 clock 11 ok", 8'h00);
        rd_first(8'h94, v); chk("R6 clock read", v, 8'h56);
        wr1(8'h93, 8'h01); expect_status("R6 clock 01 bad", 8'h08);
        wr1(8'h93, 8'h02); expect_status("R6 clock 10 bad", 8'h08);
        wr1(8'h93, 8'h00); expect_status("R6 clock 00 ok", 8'h00);
    endtask

    task automatic t_unknown;
        logic [7:0] v;
        wr1(8'h99, 8'h00);
        expect_status("R10 unknown write", 8'h08);
        rd_first(8'h8D, v); chk("R10 unknown read data", v, 8'h00);
        rd_first(8'h8C, v); chk("R10 err bits", v, 8'h03);
        expect_status("R10 unknown read status", 8'h08);
    endtask

    task automatic t_pwm;
        start(1); wbyte(8'h95); wbyte(8'h05); wbyte(8'hAB); wbyte(8'hCD);
        scr_raddr = 8'h05; #1 chk("R11 word at 5", scr_rdata, 16'hABCD);
        expect_status("R11 good write", 8'h00);
        start(1); wbyte(8'h95); wbyte(8'hED); wbyte(8'h12); wbyte(8'h34);
        scr_raddr = 8'hED; #1 chk("R11 word at top 59", scr_rdata, 16'h1234);
        start(1); wbyte(8'h95); wbyte(8'h04);
        expect_status("R11 low bits 0 bad", 8'h08);
        start(1); wbyte(8'h95); wbyte(8'hF1);
        expect_status("R11 address 60 bad", 8'h08);
        scr_raddr = 8'h05; #1 chk("R11 word 5 kept", scr_rdata, 16'hABCD);
    endtask

    task automatic t_engine;
        wr1(8'h96, 8'h0E);
        chk("R12 start pulse", cap_go, 1);  chk("R12 start sel", cap_sel, 2);
        chk("R12 start addr", cap_addr, 3);
        @(negedge clk); chk("R12 pulse one cycle", eng_start, 0);
        wr1(8'h97, 8'h01);
        chk("R12 stop pulse", cap_halt, 1);  chk("R12 stop sel", cap_sel, 1);
        wr1(8'h97, 8'h00);
        chk("R12 stop 0 no pulse", cap_halt, 0);
        expect_status("R12 stop 0 bad", 8'h08);
        wr1(8'h96, 8'hF3);
        chk("R12 start 60 no pulse", cap_go, 0);
        expect_status("R12 start 60 bad", 8'h08);
    endtask

    task automatic t_reset_cmd;
        wr1(8'h8B, 8'h20);
        chk("R3 act set", act_time, 8'h20);
        wr1(8'h83, 8'h55);
        chk("R3 bad key keeps act", act_time, 8'h20);
        expect_status("R3 bad key status", 8'h08);
        wr1(8'h83, 8'hAA);
        chk("R3 act restored", act_time, 125);  chk("R3 cfg restored", cfg_byte, 8'h80);
        chk("R3 size restored", key_size, 8'h33); chk("R3 clk restored", clk_cfg, 8'h08);
        chk("R3 irq_n low", irq_n, 0);
        expect_status("R3 status noinit", 8'h10);
    endtask

    task automatic t_direction;
        start(0); wbyte(8'h81); wbyte(8'h11);
        chk("R1 write ignored in read xfer", cfg_byte, 8'h80);
        chk("R1 status untouched", irq_n, 0);
        start(1); wbyte(8'h85); wbyte(8'h0F); start(1); wbyte(8'h86); wbyte(8'h0F);
        chk("R1 restart drops partial", gpio_dir, 16'h000F);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_id_cfg; t_gpio; t_spent; t_keysize; t_clock;
        t_unknown; t_pwm; t_engine; t_reset_cmd; t_direction;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule